// File: doc/BRIEF.md
# Predictive Low-Latency Bit Synchronizer

This block brings a single-bit level from a source clock domain into a destination clock domain whose period relation to the source is fixed and known, with jitter held inside a bounded window. Because both periods are fixed, the destination edges that can land close to a source edge recur on a fixed beat. A phase counter in the destination domain tracks that beat. It raises a danger flag in the one cycle per beat that follows a risky sample.

In a safe cycle the output is taken straight from the first capture flop, so a change shows one destination cycle after it is sampled. In a danger cycle a 2:1 select hides the first flop, which may still be resolving, and shows the second flop of a classic two-flop chain instead. After reset the select stays on the two-flop path for one full beat. It only starts choosing per cycle once the counter has wrapped for the first time.

Top module: `pred_sync`

## Requirements
- R1: While rst_ni is low, data_o is 0 whatever data_i does.
- R2: The phase counter is 0 after reset and advances by one on every clk_i edge. It wraps from PERIOD-1 to 0, so exactly one cycle in every PERIOD cycles is a danger cycle: the cycle in which the counter equals OFFSET.
- R3: Once running, in every non-danger cycle data_o equals the data_i value sampled at the most recent clk_i edge (one-cycle latency).
- R4: Once running, in every danger cycle data_o equals the data_i value sampled two clk_i edges earlier (two-cycle latency).
- R5: Number the clk_i edges after reset release 1, 2, 3 and so on. After edges 1 to PERIOD-1 (warm-up), data_o shows the two-flop path: 0 after edge 1, then the data_i value sampled one edge before the latest one. Per-cycle selection starts after edge PERIOD.
- R6: A data_i change captured at an edge that begins a danger cycle does not show on data_o in that cycle. data_o keeps the value it had in the cycle before, and the change appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Destination-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 1 | Level from the source clock domain |
| data_o | output | 1 | Synchronized level in the destination domain |

## Verification
The bench builds the block with PERIOD=5 and OFFSET=3, not the defaults of 4 and 0. This places the danger cycle away from the counter wrap. The warm-up then covers four edges, and a fast cycle falls both before and after each danger cycle. With these values, the bench can drive data_i changes that land only on danger edges and check that each one is delayed by exactly one extra cycle. The same run also covers toggling, constant and random inputs across many beats.

// File: rtl/pred_sync_pkg.sv
package pred_sync_pkg;
  typedef enum logic {PATH_FAST = 1'b0, PATH_SAFE = 1'b1} path_e;
  typedef enum logic {ST_WARM = 1'b0, ST_RUN = 1'b1} mode_e;
endpackage

// File: rtl/pred_sync_phase_ctr.sv
module pred_sync_phase_ctr #(
  parameter int PERIOD = 4,
  parameter int OFFSET = 0,
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o,
  output logic          danger_o
);
  logic [CW-1:0] cnt_q;

  assign wrap_o   = (cnt_q == CW'(PERIOD - 1));
  assign danger_o = (cnt_q == CW'(OFFSET));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/pred_sync_path_fsm.sv
module pred_sync_path_fsm
  import pred_sync_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wrap_i,
  input  logic  danger_i,
  output logic  run_o,
  output path_e sel_o
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (mode_q == ST_WARM && wrap_i) mode_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= ST_WARM;
    else         mode_q <= mode_d;
  end

  assign run_o = (mode_q == ST_RUN);
  // first flop may be resolving in a danger cycle: hide it
  assign sel_o = (run_o && !danger_i) ? PATH_FAST : PATH_SAFE;
endmodule

// File: rtl/pred_sync_chain.sv
module pred_sync_chain #(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic first_o,
  output logic last_o
);
  logic [DEPTH-1:0] st_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= 1'b0;
      else         st_q[g] <= (g == 0) ? d_i : st_q[(g == 0) ? 0 : g - 1];
    end
  end

  assign first_o = st_q[0];
  assign last_o  = st_q[DEPTH-1];
endmodule

// File: rtl/pred_sync.sv
module pred_sync
  import pred_sync_pkg::*;
#(
  parameter int PERIOD = 4,
  parameter int OFFSET = 0,
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic data_o
);
  logic [CW-1:0] cnt_q;
  logic          wrap;
  logic          danger;
  logic          run;
  path_e         sel;
  logic          fast_bit;
  logic          safe_bit;

  pred_sync_phase_ctr #(.PERIOD(PERIOD), .OFFSET(OFFSET)) i_ctr (
    .clk_i, .rst_ni, .cnt_o(cnt_q), .wrap_o(wrap), .danger_o(danger)
  );

  pred_sync_path_fsm i_fsm (
    .clk_i, .rst_ni, .wrap_i(wrap), .danger_i(danger), .run_o(run), .sel_o(sel)
  );

  pred_sync_chain #(.DEPTH(2)) i_chain (
    .clk_i, .rst_ni, .d_i(data_i), .first_o(fast_bit), .last_o(safe_bit)
  );

  assign data_o = (sel == PATH_SAFE) ? safe_bit : fast_bit;
endmodule

// File: rtl/pred_sync_chk.sv
module pred_sync_chk #(
  parameter int PERIOD = 4,
  parameter int OFFSET = 0,
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          data_i,
  input logic          data_o,
  input logic [CW-1:0] cnt,
  input logic          danger,
  input logic          run
);
  assert_reset_low_R1: assert property (@(posedge clk_i)
    !rst_ni |-> data_o == 1'b0);

  assert_cnt_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == CW'(PERIOD - 1) |=> cnt == '0);

  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt != CW'(PERIOD - 1) |=> cnt == $past(cnt) + CW'(1));

  assert_fast_path_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !danger) |-> data_o == $past(data_i));

  assert_safe_path_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && danger) |-> data_o == $past(data_i, 2));

  assert_danger_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && danger) |-> data_o == $past(data_o));
endmodule

bind pred_sync pred_sync_chk #(.PERIOD(PERIOD), .OFFSET(OFFSET)) i_chk (
  .clk_i, .rst_ni, .data_i, .data_o, .cnt(cnt_q), .danger(danger), .run(run)
);

// File: tb/test_pred_sync.sv
`timescale 1ns/1ps
module test_pred_sync;
  localparam int P   = 5;
  localparam int OFF = 3;

  typedef struct {
    logic  exp;
    logic  dng;
    string tag;
  } item_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic data_i = 1'b0;
  logic data_o;

  int n_chk = 0;
  int n_bad = 0;
  int k = 0;
  logic prev_d = 1'b0;
  logic last_obs = 1'b0;
  bit done = 1'b0;
  item_t q[$];

  always #2.5 clk_i = ~clk_i;

  pred_sync #(.PERIOD(P), .OFFSET(OFFSET_V())) i_pred_sync (
    .clk_i, .rst_ni, .data_i, .data_o
  );

  function automatic int OFFSET_V();
    return OFF;
  endfunction

  task automatic check(input bit ok, input string tag, input logic act, input logic exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: data_o=%0b expected %0b (edge %0d)", tag, act, exp, k);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // driver: call at a negedge; drives data_i for the next edge and queues its expectation
  task automatic step(input logic v);
    item_t it;
    bit run, dng, safe;
    data_i = v;
    k++;
    run  = (k >= P);
    dng  = ((k % P) == OFF);
    safe = !run || dng;
    it.exp = safe ? prev_d : v;
    it.dng = run && dng;
    it.tag = !run ? "R5" : (dng ? "R4/R2" : "R3/R2");
    q.push_back(it);
    prev_d = v;
    @(negedge clk_i);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(data_o === it.exp, it.tag, data_o, it.exp);
        if (it.dng) check(data_o === last_obs, "R6", data_o, last_obs);
        last_obs = data_o;
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    // R1: reset holds output low while input toggles
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      data_i = ~data_i;
      #0.5;
      check(data_o === 1'b0, "R1", data_o, 1'b0);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    prev_d = 1'b0;
    // warm-up and alternating pattern (R5, R3, R4)
    for (int i = 0; i < 3 * P; i++) step(i[0] ? 1'b0 : 1'b1);
    // constant ones then zeros
    for (int i = 0; i < 2 * P; i++) step(1'b1);
    for (int i = 0; i < 2 * P; i++) step(1'b0);
    // random
    for (int i = 0; i < 60; i++) step(1'($urandom));
    // R6: source changes only land on danger edges
    for (int i = 0; i < 8 * P; i++) begin
      logic v;
      v = (((k + 1) % P) == OFF) ? ~prev_d : prev_d;
      step(v);
    end
    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule